// File: doc/BRIEF.md
# NAND Host Operation Sequencer

This block sits on the host side of a raw 8-bit NAND flash bus. A client hands it one request at a time: fetch part of a page, program a page, erase a block, fetch the status byte, or reset the device. The block expands each request into the bus cycles that request needs. It drives the command-latch, address-latch, chip-select, write-strobe and read-strobe lines and the shared data byte. Every strobe phase lasts a whole number of clock cycles, and each phase length is a parameter.

Page data leaves the block through a byte-wide valid/ready stream. Program data enters through a second stream of the same kind. When a request ends, the block raises a one-cycle `done` flag together with a pass flag, a timeout flag and the last status byte read. Completion of a long operation is found either through the ready/busy line or by polling status bit 6. A busy period that runs past a cycle limit ends the request with a timeout.

Top module: `nand_op_sequencer`

## Requirements
- R1: After reset the bus is at rest: `nf_ce_n`, `nf_we_n` and `nf_re_n` are 1, `nf_dq_oe` is 0, `req_ready` is 1, and `done` and `rd_valid` are 0.
- R2: A read request (`req_op`=0) latches command 00h, then address bytes column, row[7:0] and row[15:8]. It waits for ready, then delivers `req_len` bytes in column order on the read stream. Every read starts with 00h, so a device left in status mode returns page data again.
- R3: A program request (`req_op`=1) latches 80h, the same three address bytes, `req_len` data bytes taken in stream order, 10h, and after the busy period 70h.
- R4: An erase request (`req_op`=2) latches 60h, row[7:0], row[15:8], D0h and, after the busy period, 70h. No column byte is sent.
- R5: Each write-strobe low phase lasts at least `WE_LOW` cycles with the data byte held still. Consecutive falling edges are at least `WE_LOW`+`WE_HIGH` cycles apart. The byte stays driven for at least 3 cycles after the rising edge.
- R6: No read-strobe fall comes sooner than `WHR_CYC` cycles after the last write-strobe rise.
- R7: A program or erase is complete when `nf_rb` is 1 and a status byte read after 70h has bit 6 set. While bit 6 reads 0, the status byte is read again without a new command.
- R8: `done_status` carries the final status byte. For program, erase and status requests, `done_ok` is 1 exactly when status bit 0 is 0.
- R9: If a wait for the device runs `BUSY_MAX` cycles without completion, the request ends with `done_timeout`=1 and `done_ok`=0.
- R10: A status request (`req_op`=3) latches only 70h and reads one byte. A reset request (`req_op`=4) latches only FFh, waits for ready and ends with `done_ok`=1.
- R11: `rd_data` holds steady while `rd_valid` is 1 and `rd_ready` is 0. No read strobe is issued while `rd_valid` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block idle, request taken |
| req_op | input | 3 | 0 read, 1 program, 2 erase, 3 status, 4 reset |
| req_row | input | 16 | Row (page) address |
| req_col | input | 8 | Starting column |
| req_len | input | LEN_W | Bytes to move, 1 to 528 |
| wr_valid | input | 1 | Program byte offered |
| wr_ready | output | 1 | Program byte taken |
| wr_data | input | 8 | Program byte |
| rd_valid | output | 1 | Page byte available |
| rd_ready | input | 1 | Consumer accepts page byte |
| rd_data | output | 8 | Page byte |
| done | output | 1 | One-cycle end-of-request flag |
| done_ok | output | 1 | Request passed |
| done_timeout | output | 1 | Busy wait expired |
| done_status | output | 8 | Last status byte read |
| nf_ce_n | output | 1 | Chip select, active low |
| nf_cle | output | 1 | Command latch enable |
| nf_ale | output | 1 | Address latch enable |
| nf_we_n | output | 1 | Write strobe, active low |
| nf_re_n | output | 1 | Read strobe, active low |
| nf_dq_out | output | 8 | Byte driven to the device |
| nf_dq_oe | output | 1 | Drive enable for `nf_dq_out` |
| nf_dq_in | input | 8 | Byte returned by the device |
| nf_rb | input | 1 | Ready (1) / busy (0) |

## Verification
`done` rises in the cycle after the last strobe phase or stream handshake of a request. A read byte appears on `rd_data` in the cycle after its read-strobe high phase ends. The bench reads results at falling clock edges and waits on `done` and the stream handshakes rather than on fixed cycle counts, because busy periods and back-pressure vary from run to run. An attached device model logs each byte latched on a write-strobe rise. It counts strobe phase lengths at every falling edge, so the cycle minimums are measured where they occur.

// File: rtl/nseq_pkg.sv
package nseq_pkg;

  typedef enum logic [2:0] {
    OP_READ   = 3'd0,
    OP_PROG   = 3'd1,
    OP_ERASE  = 3'd2,
    OP_STATUS = 3'd3,
    OP_RESET  = 3'd4
  } op_e;

  localparam logic [7:0] CMD_STATUS = 8'h70;

  // Opening command byte for each request kind
  function automatic logic [7:0] lead_cmd(input op_e op);
    case (op)
      OP_READ:   return 8'h00;
      OP_PROG:   return 8'h80;
      OP_ERASE:  return 8'h60;
      OP_STATUS: return CMD_STATUS;
      default:   return 8'hFF;
    endcase
  endfunction

  // Second (execute) command byte for two-step requests
  function automatic logic [7:0] exec_cmd(input op_e op);
    return (op == OP_ERASE) ? 8'hD0 : 8'h10;
  endfunction

  function automatic logic [1:0] addr_bytes(input op_e op);
    case (op)
      OP_READ, OP_PROG: return 2'd3;
      OP_ERASE:         return 2'd2;
      default:          return 2'd0;
    endcase
  endfunction

  // Address byte number idx; erase skips the column byte
  function automatic logic [7:0] addr_pick(input op_e op, input logic [1:0] idx,
                                           input logic [7:0] col, input logic [15:0] row);
    if (op == OP_ERASE) return (idx == 2'd0) ? row[7:0] : row[15:8];
    case (idx)
      2'd0:    return col;
      2'd1:    return row[7:0];
      default: return row[15:8];
    endcase
  endfunction

endpackage

// File: rtl/nseq_cycle.sv
module nseq_cycle #(
  parameter int WE_LOW  = 7,
  parameter int WE_HIGH = 6,
  parameter int RE_LOW  = 9,
  parameter int RE_HIGH = 4,
  parameter int GAP_W   = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             go,
  input  logic             go_read,
  input  logic             go_cle,
  input  logic             go_ale,
  input  logic [7:0]       go_byte,
  input  logic [GAP_W-1:0] go_gap,
  input  logic [7:0]       dq_in,
  output logic             busy,
  output logic             fin,
  output logic [7:0]       rbyte,
  output logic             we_n,
  output logic             re_n,
  output logic             cle,
  output logic             ale,
  output logic [7:0]       dq_out,
  output logic             dq_oe
);
  localparam int M1   = (WE_LOW > WE_HIGH) ? WE_LOW : WE_HIGH;
  localparam int M2   = (RE_LOW > RE_HIGH) ? RE_LOW : RE_HIGH;
  localparam int M3   = (M1 > M2) ? M1 : M2;
  localparam int MAXV = (M3 > (1 << GAP_W)) ? M3 : (1 << GAP_W);
  localparam int CW   = $clog2(MAXV + 1);

  typedef enum logic [1:0] {E_IDLE, E_GAP, E_LOW, E_HIGH} ph_e;

  ph_e           ph;
  logic [CW-1:0] cnt;
  logic          rd;
  logic [7:0]    byte_q;

  function automatic logic [CW-1:0] low_len(input logic r);
    return r ? CW'(RE_LOW) : CW'(WE_LOW);
  endfunction

  function automatic logic [CW-1:0] high_len(input logic r);
    return r ? CW'(RE_HIGH) : CW'(WE_HIGH);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph     <= E_IDLE;
      cnt    <= '0;
      rd     <= 1'b0;
      cle    <= 1'b0;
      ale    <= 1'b0;
      dq_oe  <= 1'b0;
      byte_q <= '0;
      rbyte  <= '0;
    end else begin
      case (ph)
        E_IDLE: if (go) begin
          rd     <= go_read;
          cle    <= go_cle;
          ale    <= go_ale;
          dq_oe  <= !go_read;
          byte_q <= go_byte;
          if (go_gap != '0) begin
            ph  <= E_GAP;
            cnt <= CW'(go_gap) - CW'(1);
          end else begin
            ph  <= E_LOW;
            cnt <= low_len(go_read) - CW'(1);
          end
        end
        E_GAP: begin
          if (cnt == '0) begin
            ph  <= E_LOW;
            cnt <= low_len(rd) - CW'(1);
          end else cnt <= cnt - CW'(1);
        end
        E_LOW: begin
          if (cnt == '0) begin
            if (rd) rbyte <= dq_in;
            ph  <= E_HIGH;
            cnt <= high_len(rd) - CW'(1);
          end else cnt <= cnt - CW'(1);
        end
        default: begin
          if (cnt == '0) begin
            ph    <= E_IDLE;
            cle   <= 1'b0;
            ale   <= 1'b0;
            dq_oe <= 1'b0;
          end else cnt <= cnt - CW'(1);
        end
      endcase
    end
  end

  assign busy   = (ph != E_IDLE);
  assign fin    = (ph == E_HIGH) && (cnt == '0);
  assign we_n   = !((ph == E_LOW) && !rd);
  assign re_n   = !((ph == E_LOW) && rd);
  assign dq_out = byte_q;

  // Length of the current write-strobe low run, for the width check
  logic [15:0] we_run;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) we_run <= '0;
    else if (!we_n) we_run <= (we_run == 16'hFFFF) ? we_run : we_run + 16'd1;
    else we_run <= '0;
  end

  a_r5_we_min_low: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(we_n) |-> (we_run >= 16'(WE_LOW)));
  a_r5_dq_still_low: assert property (@(posedge clk) disable iff (!rst_n)
    (!we_n && $past(!we_n)) |-> $stable(dq_out));
  a_r5_dq_held_rise: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(we_n) |-> (dq_oe && $stable(dq_out)));

endmodule

// File: rtl/nseq_busy_timer.sv
module nseq_busy_timer #(
  parameter int LIMIT = 131072,
  parameter int TW    = $clog2(LIMIT + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          en,
  output logic [TW-1:0] count,
  output logic          expired
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) count <= '0;
    else if (clr) count <= '0;
    else if (en && (count < TW'(LIMIT))) count <= count + TW'(1);
  end

  assign expired = (count >= TW'(LIMIT));

  a_r9_clear_restarts: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (count == '0));

endmodule

// File: rtl/nand_op_sequencer.sv
module nand_op_sequencer
  import nseq_pkg::*;
#(
  parameter int WE_LOW   = 7,
  parameter int WE_HIGH  = 6,
  parameter int RE_LOW   = 9,
  parameter int RE_HIGH  = 4,
  parameter int WHR_CYC  = 15,
  parameter int RR_CYC   = 5,
  parameter int WB_CYC   = 25,
  parameter int BUSY_MAX = 131072,
  parameter int LEN_W    = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [2:0]       req_op,
  input  logic [15:0]      req_row,
  input  logic [7:0]       req_col,
  input  logic [LEN_W-1:0] req_len,
  input  logic             wr_valid,
  output logic             wr_ready,
  input  logic [7:0]       wr_data,
  output logic             rd_valid,
  input  logic             rd_ready,
  output logic [7:0]       rd_data,
  output logic             done,
  output logic             done_ok,
  output logic             done_timeout,
  output logic [7:0]       done_status,
  output logic             nf_ce_n,
  output logic             nf_cle,
  output logic             nf_ale,
  output logic             nf_we_n,
  output logic             nf_re_n,
  output logic [7:0]       nf_dq_out,
  output logic             nf_dq_oe,
  input  logic [7:0]       nf_dq_in,
  input  logic             nf_rb
);
  localparam int GAP_MAX = (WHR_CYC > RR_CYC) ? WHR_CYC : RR_CYC;
  localparam int GAP_W   = $clog2(GAP_MAX + 1);
  localparam int TW      = $clog2(BUSY_MAX + 1);

  typedef enum logic [3:0] {
    S_IDLE, S_CMD1, S_ADDR, S_DIN, S_CMD2, S_WB, S_WAITRB,
    S_SCMD, S_SRD, S_RDB, S_RDOUT, S_DONE
  } st_e;

  st_e              st;
  op_e              op;
  logic [15:0]      row;
  logic [7:0]       col;
  logic [LEN_W-1:0] len;
  logic [1:0]       aidx;
  logic [LEN_W-1:0] xcnt;
  logic             issued;
  logic             sfirst;

  // Named internal events
  logic             go, go_read, go_cle, go_ale, want_cycle;
  logic [7:0]       go_byte;
  logic [GAP_W-1:0] go_gap;
  logic             eng_busy, eng_fin;
  logic [7:0]       eng_rbyte;
  logic             tmr_en, tmr_expired;
  logic [TW-1:0]    tmr_count;
  logic             last_addr, last_xfer;

  assign want_cycle = (st == S_CMD1) || (st == S_ADDR) || (st == S_DIN) || (st == S_CMD2)
                   || (st == S_SCMD) || (st == S_SRD) || (st == S_RDB);
  assign go      = want_cycle && !issued && !eng_busy && ((st != S_DIN) || wr_valid);
  assign go_read = (st == S_SRD) || (st == S_RDB);
  assign go_cle  = (st == S_CMD1) || (st == S_CMD2) || (st == S_SCMD);
  assign go_ale  = (st == S_ADDR);
  assign wr_ready = (st == S_DIN) && go;
  assign last_addr = (aidx == addr_bytes(op) - 2'd1);
  assign last_xfer = (xcnt == len - LEN_W'(1));

  always_comb begin
    case (st)
      S_CMD1:  go_byte = lead_cmd(op);
      S_ADDR:  go_byte = addr_pick(op, aidx, col, row);
      S_DIN:   go_byte = wr_data;
      S_CMD2:  go_byte = exec_cmd(op);
      S_SCMD:  go_byte = CMD_STATUS;
      default: go_byte = 8'h00;
    endcase
    if (st == S_SRD && sfirst)             go_gap = GAP_W'(WHR_CYC);
    else if (st == S_RDB && xcnt == '0)    go_gap = GAP_W'(RR_CYC);
    else                                   go_gap = '0;
  end

  nseq_cycle #(
    .WE_LOW(WE_LOW), .WE_HIGH(WE_HIGH), .RE_LOW(RE_LOW), .RE_HIGH(RE_HIGH), .GAP_W(GAP_W)
  ) u_cycle (
    .clk(clk), .rst_n(rst_n), .go(go), .go_read(go_read), .go_cle(go_cle), .go_ale(go_ale),
    .go_byte(go_byte), .go_gap(go_gap), .dq_in(nf_dq_in), .busy(eng_busy), .fin(eng_fin),
    .rbyte(eng_rbyte), .we_n(nf_we_n), .re_n(nf_re_n), .cle(nf_cle), .ale(nf_ale),
    .dq_out(nf_dq_out), .dq_oe(nf_dq_oe)
  );

  assign tmr_en = (st == S_WB) || (st == S_WAITRB) || (st == S_SCMD) || (st == S_SRD);

  nseq_busy_timer #(.LIMIT(BUSY_MAX), .TW(TW)) u_timer (
    .clk(clk), .rst_n(rst_n), .clr(!tmr_en), .en(tmr_en),
    .count(tmr_count), .expired(tmr_expired)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st           <= S_IDLE;
      op           <= OP_READ;
      row          <= '0;
      col          <= '0;
      len          <= '0;
      aidx         <= '0;
      xcnt         <= '0;
      issued       <= 1'b0;
      sfirst       <= 1'b0;
      rd_valid     <= 1'b0;
      rd_data      <= '0;
      done_ok      <= 1'b0;
      done_timeout <= 1'b0;
      done_status  <= '0;
    end else begin
      if (go) issued <= 1'b1;
      else if (eng_fin) issued <= 1'b0;
      case (st)
        S_IDLE: if (req_valid) begin
          op   <= op_e'(req_op);
          row  <= req_row;
          col  <= req_col;
          len  <= req_len;
          aidx <= '0;
          xcnt <= '0;
          st   <= S_CMD1;
        end
        S_CMD1: if (eng_fin) begin
          if (addr_bytes(op) != 2'd0) st <= S_ADDR;
          else if (op == OP_STATUS) begin
            st     <= S_SRD;
            sfirst <= 1'b1;
          end else st <= S_WB;
        end
        S_ADDR: if (eng_fin) begin
          if (last_addr) begin
            aidx <= '0;
            case (op)
              OP_READ: st <= S_WB;
              OP_PROG: st <= (len == '0) ? S_CMD2 : S_DIN;
              default: st <= S_CMD2;
            endcase
          end else aidx <= aidx + 2'd1;
        end
        S_DIN: if (eng_fin) begin
          xcnt <= xcnt + LEN_W'(1);
          if (last_xfer) st <= S_CMD2;
        end
        S_CMD2: if (eng_fin) st <= S_WB;
        S_WB: if (tmr_count >= TW'(WB_CYC - 1)) st <= S_WAITRB;
        S_WAITRB: begin
          if (tmr_expired) begin
            st           <= S_DONE;
            done_ok      <= 1'b0;
            done_timeout <= 1'b1;
            done_status  <= 8'h00;
          end else if (nf_rb) begin
            case (op)
              OP_READ: begin
                st   <= S_RDB;
                xcnt <= '0;
              end
              OP_PROG, OP_ERASE: st <= S_SCMD;
              default: begin
                st           <= S_DONE;
                done_ok      <= 1'b1;
                done_timeout <= 1'b0;
                done_status  <= 8'h00;
              end
            endcase
          end
        end
        S_SCMD: if (eng_fin) begin
          st     <= S_SRD;
          sfirst <= 1'b1;
        end
        S_SRD: if (eng_fin) begin
          sfirst <= 1'b0;
          if (op == OP_STATUS || eng_rbyte[6]) begin
            st           <= S_DONE;
            done_ok      <= !eng_rbyte[0];
            done_timeout <= 1'b0;
            done_status  <= eng_rbyte;
          end else if (tmr_expired) begin
            st           <= S_DONE;
            done_ok      <= 1'b0;
            done_timeout <= 1'b1;
            done_status  <= eng_rbyte;
          end
        end
        S_RDB: if (eng_fin) begin
          rd_data  <= eng_rbyte;
          rd_valid <= 1'b1;
          st       <= S_RDOUT;
        end
        S_RDOUT: if (rd_ready) begin
          rd_valid <= 1'b0;
          xcnt     <= xcnt + LEN_W'(1);
          if (last_xfer) begin
            st           <= S_DONE;
            done_ok      <= 1'b1;
            done_timeout <= 1'b0;
            done_status  <= 8'h00;
          end else st <= S_RDB;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign req_ready = (st == S_IDLE);
  assign done      = (st == S_DONE);
  assign nf_ce_n   = (st == S_IDLE) || (st == S_DONE);

  // Cycles since the last write-strobe rise, for the turnaround check
  logic [7:0] since_we;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) since_we <= 8'hFF;
    else if (!nf_we_n) since_we <= '0;
    else if (since_we != 8'hFF) since_we <= since_we + 8'd1;
  end

  a_r1_idle_bus_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (nf_we_n && nf_re_n && !nf_dq_oe));
  a_r6_we_to_re_gap: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(nf_re_n) |-> (since_we >= 8'(WHR_CYC)));
  a_r9_timeout_fails: assert property (@(posedge clk) disable iff (!rst_n)
    (done && done_timeout) |-> !done_ok);
  a_r11_hold_byte: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_data)));
  a_r11_no_strobe_full: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> nf_re_n);

endmodule

// File: tb/nand_op_sequencer_test.sv
`timescale 1ns/1ps
module nand_op_sequencer_test;
  localparam int BMAX = 2000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic        req_valid = 1'b0, req_ready;
  logic [2:0]  req_op = 3'd0;
  logic [15:0] req_row = '0;
  logic [7:0]  req_col = '0;
  logic [9:0]  req_len = '0;
  logic        wr_valid = 1'b0, wr_ready;
  logic [7:0]  wr_data;
  logic        rd_valid, rd_ready = 1'b1;
  logic [7:0]  rd_data;
  logic        done, done_ok, done_timeout;
  logic [7:0]  done_status;
  logic        nf_ce_n, nf_cle, nf_ale, nf_we_n, nf_re_n, nf_dq_oe, nf_rb;
  logic [7:0]  nf_dq_out, nf_dq_in = 8'h00;

  nand_op_sequencer #(.BUSY_MAX(BMAX)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready), .req_op(req_op),
    .req_row(req_row), .req_col(req_col), .req_len(req_len), .wr_valid(wr_valid),
    .wr_ready(wr_ready), .wr_data(wr_data), .rd_valid(rd_valid), .rd_ready(rd_ready),
    .rd_data(rd_data), .done(done), .done_ok(done_ok), .done_timeout(done_timeout),
    .done_status(done_status), .nf_ce_n(nf_ce_n), .nf_cle(nf_cle), .nf_ale(nf_ale),
    .nf_we_n(nf_we_n), .nf_re_n(nf_re_n), .nf_dq_out(nf_dq_out), .nf_dq_oe(nf_dq_oe),
    .nf_dq_in(nf_dq_in), .nf_rb(nf_rb)
  );

  int n_checks = 0, n_fail = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Page content seen by the model
  function automatic logic [7:0] page_byte(input int r, input int c);
    return 8'((r & 255) ^ (r >> 8)) + 8'(c * 5) + 8'(c >> 8);
  endfunction

  // ---------------- device model ----------------
  int   busy_len = 50;
  bit   fail_flag = 0, rb_tied = 0, bp_en = 0;
  int   m_busy = 0, m_addr_n = 0, m_row = 0, m_ptr = 0, stat_reads = 0;
  bit   m_stat_mode = 0;
  logic [7:0] m_last_cmd = 8'hFF;
  int   log_kind [0:599];
  logic [7:0] log_byte [0:599];
  int   log_n = 0;
  bit   prev_we = 1, prev_re = 1;
  int   we_low_run = 0, fall_run = 1000, hold_left = 0, since_we = 1000;
  logic [7:0] hold_b = 0, prev_dq = 0;
  int   v_r5 = 0, v_r6 = 0, v_r11 = 0;

  assign nf_rb = rb_tied || (m_busy == 0);

  always @(negedge clk) begin
    if (m_busy > 0) m_busy--;
    if (hold_left > 0) begin
      if (!nf_dq_oe || nf_dq_out != hold_b) v_r5++;
      hold_left--;
    end
    if (!nf_we_n && !prev_we && nf_dq_out != prev_dq) v_r5++;
    if (!nf_we_n) we_low_run++;
    if (prev_we && !nf_we_n) begin
      if (fall_run < 13) v_r5++;
      fall_run = 0;
    end
    fall_run++;
    if (!prev_we && nf_we_n) begin
      if (we_low_run < 7) v_r5++;
      we_low_run = 0;
      since_we = 0;
      hold_left = 3;
      hold_b = nf_dq_out;
      if (nf_cle) begin
        log_kind[log_n] = 1; log_byte[log_n] = nf_dq_out; log_n++;
        m_last_cmd = nf_dq_out;
        case (nf_dq_out)
          8'h00: begin m_stat_mode = 0; m_addr_n = 0; end
          8'h80, 8'h60: begin m_stat_mode = 0; m_addr_n = 0; end
          8'h70: m_stat_mode = 1;
          8'h10, 8'hD0: m_busy = busy_len;
          8'hFF: begin m_stat_mode = 0; m_busy = busy_len; end
          default: ;
        endcase
      end else if (nf_ale) begin
        log_kind[log_n] = 2; log_byte[log_n] = nf_dq_out; log_n++;
        if (m_last_cmd == 8'h60) begin
          if (m_addr_n == 0) m_row = (m_row & 'hFF00) | nf_dq_out;
          else m_row = (m_row & 'hFF) | (int'(nf_dq_out) << 8);
        end else begin
          if (m_addr_n == 0) m_ptr = nf_dq_out;
          else if (m_addr_n == 1) m_row = (m_row & 'hFF00) | nf_dq_out;
          else begin
            m_row = (m_row & 'hFF) | (int'(nf_dq_out) << 8);
            if (m_last_cmd == 8'h00) m_busy = busy_len;
          end
        end
        m_addr_n++;
      end else begin
        log_kind[log_n] = 3; log_byte[log_n] = nf_dq_out; log_n++;
      end
    end else if (nf_we_n) since_we++;
    if (prev_re && !nf_re_n) begin
      if (since_we < 15) v_r6++;
      if (rd_valid) v_r11++;
      if (m_stat_mode) begin
        nf_dq_in = {1'b1, (m_busy == 0), 5'b0, fail_flag};
        stat_reads++;
      end else begin
        nf_dq_in = page_byte(m_row, m_ptr);
        m_ptr = (m_ptr + 1) % 528;
      end
    end
    prev_we = nf_we_n;
    prev_re = nf_re_n;
    prev_dq = nf_dq_out;
    rd_ready = bp_en ? (($urandom % 3) != 0) : 1'b1;
  end

  // ---------------- streams ----------------
  logic [7:0] prog_buf [0:527];
  int widx = 0;
  logic [7:0] rd_cap [0:527];
  int rd_n = 0;
  assign wr_data = prog_buf[widx % 528];
  always @(posedge clk) begin
    if (wr_valid && wr_ready) widx <= widx + 1;
    if (rd_valid && rd_ready) begin
      rd_cap[rd_n % 528] <= rd_data;
      rd_n <= rd_n + 1;
    end
  end

  // ---------------- expected sequence ----------------
  int exp_kind [0:599];
  logic [7:0] exp_byte [0:599];
  int exp_n = 0;

  task automatic push(input int k, input logic [7:0] b);
    exp_kind[exp_n] = k; exp_byte[exp_n] = b; exp_n++;
  endtask

  task automatic build_exp(input int op, input int row, input int col, input int len);
    exp_n = 0;
    case (op)
      0: begin push(1, 8'h00); push(2, 8'(col)); push(2, 8'(row)); push(2, 8'(row >> 8)); end
      1: begin
        push(1, 8'h80); push(2, 8'(col)); push(2, 8'(row)); push(2, 8'(row >> 8));
        for (int i = 0; i < len; i++) push(3, prog_buf[i]);
        push(1, 8'h10); push(1, 8'h70);
      end
      2: begin push(1, 8'h60); push(2, 8'(row)); push(2, 8'(row >> 8)); push(1, 8'hD0); push(1, 8'h70); end
      3: push(1, 8'h70);
      default: push(1, 8'hFF);
    endcase
  endtask

  task automatic check_seq(input string req);
    int bad = -1;
    if (log_n == exp_n)
      for (int i = 0; i < exp_n; i++)
        if (bad < 0 && (log_kind[i] != exp_kind[i] || log_byte[i] !== exp_byte[i])) bad = i;
    if (log_n != exp_n) chk(0, req, "latched byte count", log_n, exp_n);
    else if (bad >= 0) chk(0, req, $sformatf("latched byte %0d", bad), int'(log_byte[bad]), int'(exp_byte[bad]));
    else chk(1, req, "sequence", 0, 0);
  endtask

  bit r_ok, r_to;
  logic [7:0] r_st;

  task automatic do_op(input int op, input int row, input int col, input int len);
    int w = 0;
    log_n = 0; stat_reads = 0;
    rd_n = 0; widx = 0;
    @(negedge clk);
    req_op = 3'(op); req_row = 16'(row); req_col = 8'(col); req_len = 10'(len);
    wr_valid = (op == 1);
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    while (!done && w < 60000) begin @(negedge clk); w++; end
    chk(done, "R2", "request completes", int'(done), 1);
    r_ok = done_ok; r_to = done_timeout; r_st = done_status;
    wr_valid = 1'b0;
    build_exp(op, row, col, len);
    w = 0;
    while ((m_busy != 0 || !req_ready) && w < 10000) begin @(negedge clk); w++; end
    repeat (4) @(negedge clk);
  endtask

  task automatic check_read(input int row, input int col, input int len);
    int bad = -1;
    for (int i = 0; i < len; i++)
      if (bad < 0 && rd_cap[i] !== page_byte(row, (col + i) % 528)) bad = i;
    chk(rd_n == len, "R2", "bytes delivered", rd_n, len);
    if (bad >= 0) chk(0, "R2", $sformatf("page byte %0d", bad), int'(rd_cap[bad]), int'(page_byte(row, (col + bad) % 528)));
    else chk(1, "R2", "page data", 0, 0);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < 528; i++) prog_buf[i] = 8'($urandom);
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 rest state
    chk(req_ready && nf_ce_n && nf_we_n && nf_re_n && !nf_dq_oe && !done && !rd_valid,
        "R1", "rest state", {req_ready, nf_ce_n, nf_we_n, nf_re_n, nf_dq_oe, done, rd_valid}, 7'b1111000);

    // R2 plain read
    busy_len = 60;
    do_op(0, 16'h1234, 8'h10, 8);
    check_seq("R2"); check_read(16'h1234, 8'h10, 8);
    chk(r_ok && !r_to, "R2", "read ok", r_ok, 1);

    // R10/R8 status request reporting a failure bit
    fail_flag = 1;
    do_op(3, 0, 0, 1);
    check_seq("R10");
    chk(r_st == 8'hC1, "R8", "status byte", r_st, 8'hC1);
    chk(!r_ok, "R8", "fail from bit0", r_ok, 0);
    fail_flag = 0;

    // R2 read after status mode must give page data
    do_op(0, 16'h00A5, 8'hF0, 6);
    check_seq("R2"); check_read(16'h00A5, 8'hF0, 6);

    // R3 program pass
    busy_len = 300;
    do_op(1, 16'h0F0F, 8'h22, 12);
    check_seq("R3");
    chk(r_ok && r_st == 8'hC0, "R3", "program pass status", r_st, 8'hC0);

    // R8 program fail
    fail_flag = 1;
    do_op(1, 16'h0101, 8'h00, 3);
    check_seq("R8");
    chk(!r_ok && r_st == 8'hC1, "R8", "program fail status", r_st, 8'hC1);
    fail_flag = 0;

    // R4 erase
    busy_len = 200;
    do_op(2, 16'hBEEF, 8'h55, 0);
    check_seq("R4");
    chk(r_ok && !r_to, "R4", "erase ok", r_ok, 1);

    // R7 ready line never drops: completion found by polling status bit 6
    rb_tied = 1;
    do_op(2, 16'h4321, 0, 0);
    check_seq("R7");
    chk(r_ok && r_st[6], "R7", "final status bit6", r_st, 8'hC0);
    chk(stat_reads > 1, "R7", "status re-read while busy", stat_reads, 2);
    rb_tied = 0;

    // R9 timeout
    busy_len = BMAX + 600;
    do_op(2, 16'h0007, 0, 0);
    chk(r_to && !r_ok, "R9", "timeout flagged", {r_to, r_ok}, 2'b10);

    // R10 reset request
    busy_len = 40;
    do_op(4, 0, 0, 0);
    check_seq("R10");
    chk(r_ok && !r_to, "R10", "reset ok", r_ok, 1);

    // R2/R11 full page under back-pressure
    bp_en = 1;
    busy_len = 100;
    do_op(0, 16'h7E81, 0, 528);
    check_seq("R2"); check_read(16'h7E81, 0, 528);

    // random mix
    for (int k = 0; k < 20; k++) begin
      int op = $urandom % 3;
      int row = $urandom & 16'hFFFF;
      int col = $urandom % 256;
      int len = 1 + ($urandom % 24);
      busy_len = 30 + ($urandom % 300);
      fail_flag = (op != 0) && ($urandom % 2);
      bp_en = $urandom % 2;
      for (int i = 0; i < 528; i++) prog_buf[i] = 8'($urandom);
      do_op(op, row, col, len);
      check_seq(op == 0 ? "R2" : (op == 1 ? "R3" : "R4"));
      if (op == 0) check_read(row, col, len);
      else chk(r_ok == !fail_flag, "R8", "pass flag", r_ok, !fail_flag);
    end
    bp_en = 0;

    chk(v_r5 == 0, "R5", "write strobe timing violations", v_r5, 0);
    chk(v_r6 == 0, "R6", "write-to-read turnaround violations", v_r6, 0);
    chk(v_r11 == 0, "R11", "read strobe while output full", v_r11, 0);

    finished = 1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    #(190000 * 4);
    if (!finished) begin
      n_checks++; n_fail++;
      $display("FAIL R2 watchdog: actual hung expected finished");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

endmodule